// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This controller totals coins for a single-price item. Each clock it takes at most one coin (a five, ten or twenty-five cent piece) from a 2-bit code and adds its value to the credit it holds. When the running total reaches twenty cents or more, it raises a one-cycle vend pulse, reports the excess as a change code in the same cycle, and goes back to zero credit for the next customer.

The held credit can only be 0, 5, 10 or 15 cents, because a total of twenty or more is settled in the cycle it is reached. Internally all amounts are counted in nickels. The coin values and the price are parameters in those units. The outputs are Mealy outputs: they depend on the held credit and the coin present in the same cycle. The held credit itself sits in flip-flops behind a clock enable that is active only in cycles that carry a coin.

Top module: `vend_ctrl`

## Requirements
- R1: While `rst_ni` is low, the held credit is cleared to zero. After reset, with no coin present, `vend_o` and `change_o` are both 0. Credit held before a reset does not count toward a later vend.
- R2: The coin code is 00 for no coin, 01 for a nickel (5 cents), 10 for a dime (10 cents) and 11 for a quarter (25 cents). A cycle with code 00 leaves the held credit unchanged and produces no vend.
- R3: `vend_o` is 1 in exactly those cycles where the held credit plus the value of the present coin is 20 cents or more. It is combinational, so it appears in that same cycle.
- R4: In a vend cycle, `change_o` equals (held credit + coin value - 20 cents) / 5, which is the change counted in nickels. In every cycle without a vend, `change_o` is 0.
- R5: After a vend cycle, the held credit is zero.
- R6: When the total stays below 20 cents, the new total becomes the held credit at the clock edge, and it stays within 0..15 cents.
- R7: A quarter always vends. With 15 cents held, a quarter gives the largest change code, 4 (20 cents).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| coin_i | input | 2 | Coin code for this cycle |
| vend_o | output | 1 | Dispense pulse, one cycle |
| change_o | output | 3 | Change owed, in nickels, valid with vend_o |

## Verification
The bench builds the block with its default values: unit of 5 cents, coin values of 1, 2 and 5 units, and a price of 4 units. With these values the credit state space is four entries and there are four coin codes. That makes it practical to run every coin sequence of length one to four from reset, including idle codes, and compare every cycle against an integer-cents model. This sweep reaches every held credit value, every change code from 0 to 4, a vend directly after another vend, and idle cycles between coins. Separate directed sequences check that credit is discarded when reset occurs partway through a purchase.

// File: rtl/vend_pkg.sv
package vend_pkg;

  typedef enum logic [1:0] {
    COIN_NONE    = 2'b00,
    COIN_NICKEL  = 2'b01,
    COIN_DIME    = 2'b10,
    COIN_QUARTER = 2'b11
  } coin_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/vend_coin_decode.sv
module vend_coin_decode
  import vend_pkg::*;
#(
  parameter int VAL_W     = 3,
  parameter int NICKEL_U  = 1,
  parameter int DIME_U    = 2,
  parameter int QUARTER_U = 5
) (
  input  logic [1:0]       code_i,
  output logic [VAL_W-1:0] units_o,
  output logic             present_o
);

  coin_e kind;

  always_comb begin
    kind      = coin_e'(code_i);
    present_o = (kind != COIN_NONE);
    unique case (kind)
      COIN_NICKEL:  units_o = VAL_W'(NICKEL_U);
      COIN_DIME:    units_o = VAL_W'(DIME_U);
      COIN_QUARTER: units_o = VAL_W'(QUARTER_U);
      default:      units_o = '0;
    endcase
  end

endmodule

// File: rtl/vend_credit_step.sv
module vend_credit_step #(
  parameter int PRICE_U = 4,
  parameter int CR_W    = 2,
  parameter int VAL_W   = 3,
  parameter int SUM_W   = 4,
  parameter int CHG_W   = 3
) (
  input  logic [CR_W-1:0]  credit_i,
  input  logic [VAL_W-1:0] units_i,
  input  logic             present_i,
  output logic [CR_W-1:0]  credit_d_o,
  output logic             load_en_o,
  output logic             vend_o,
  output logic [CHG_W-1:0] change_o
);

  logic [SUM_W-1:0] total;
  logic [SUM_W-1:0] excess;
  logic             reached;

  always_comb begin
    total      = SUM_W'(credit_i) + SUM_W'(units_i);
    reached    = present_i && (total >= SUM_W'(PRICE_U));
    excess     = total - SUM_W'(PRICE_U);
    vend_o     = reached;
    change_o   = reached ? CHG_W'(excess) : '0;
    credit_d_o = reached ? '0 : CR_W'(total);
    load_en_o  = present_i;
  end

endmodule

// File: rtl/vend_credit_reg.sv
module vend_credit_reg #(
  parameter int CR_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [CR_W-1:0] d_i,
  output logic [CR_W-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= '0;
    end else if (en_i) begin
      q_o <= d_i;
    end
  end

endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl #(
  parameter int NICKEL_UNITS  = 1,
  parameter int DIME_UNITS    = 2,
  parameter int QUARTER_UNITS = 5,
  parameter int PRICE_UNITS   = 4,
  localparam int MAX_COIN     = vend_pkg::max3(NICKEL_UNITS, DIME_UNITS, QUARTER_UNITS),
  localparam int MAX_TOTAL    = PRICE_UNITS - 1 + MAX_COIN,
  localparam int MAX_CHANGE   = MAX_TOTAL - PRICE_UNITS,
  localparam int CR_W         = (PRICE_UNITS > 2) ? $clog2(PRICE_UNITS) : 1,
  localparam int VAL_W        = $clog2(MAX_COIN + 1),
  localparam int SUM_W        = $clog2(MAX_TOTAL + 1),
  localparam int CHG_W        = (MAX_CHANGE > 1) ? $clog2(MAX_CHANGE + 1) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       coin_i,
  output logic             vend_o,
  output logic [CHG_W-1:0] change_o
);

  logic [VAL_W-1:0] coin_units;
  logic             coin_present;
  logic [CR_W-1:0]  credit_q;
  logic [CR_W-1:0]  credit_d;
  logic             credit_en;

  vend_coin_decode #(
    .VAL_W    (VAL_W),
    .NICKEL_U (NICKEL_UNITS),
    .DIME_U   (DIME_UNITS),
    .QUARTER_U(QUARTER_UNITS)
  ) u_decode (
    .code_i   (coin_i),
    .units_o  (coin_units),
    .present_o(coin_present)
  );

  vend_credit_step #(
    .PRICE_U(PRICE_UNITS),
    .CR_W   (CR_W),
    .VAL_W  (VAL_W),
    .SUM_W  (SUM_W),
    .CHG_W  (CHG_W)
  ) u_step (
    .credit_i  (credit_q),
    .units_i   (coin_units),
    .present_i (coin_present),
    .credit_d_o(credit_d),
    .load_en_o (credit_en),
    .vend_o    (vend_o),
    .change_o  (change_o)
  );

  vend_credit_reg #(
    .CR_W(CR_W)
  ) u_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (credit_en),
    .d_i   (credit_d),
    .q_o   (credit_q)
  );

endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk #(
  parameter int PRICE_UNITS = 4,
  parameter int CR_W        = 2,
  parameter int CHG_W       = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       coin,
  input logic             vend,
  input logic [CHG_W-1:0] change,
  input logic [CR_W-1:0]  credit
);

  assert_idle_keeps_credit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (coin == 2'b00) |=> (credit == $past(credit)));

  assert_vend_needs_coin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vend |-> (coin != 2'b00));

  assert_change_only_on_vend_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !vend |-> (change == '0));

  assert_credit_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vend |=> (credit == '0));

  assert_credit_below_price_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(credit) < PRICE_UNITS));

  assert_quarter_vends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (coin == 2'b11) |-> vend);

endmodule

bind vend_ctrl vend_ctrl_chk #(
  .PRICE_UNITS(PRICE_UNITS),
  .CR_W       (CR_W),
  .CHG_W      (CHG_W)
) u_chk (
  .clk   (clk_i),
  .rst_n (rst_ni),
  .coin  (coin_i),
  .vend  (vend_o),
  .change(change_o),
  .credit(credit_q)
);

// File: tb/sim_vend_ctrl.sv
module sim_vend_ctrl;

  logic       clk;
  logic       rst_n;
  logic [1:0] coin;
  logic       vend;
  logic [2:0] change;

  int n_checks = 0;
  int n_fail   = 0;
  int model_credit;

  vend_ctrl u0 (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .coin_i  (coin),
    .vend_o  (vend),
    .change_o(change)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int cents_of(input logic [1:0] c);
    case (c)
      2'b01:   return 5;
      2'b10:   return 10;
      2'b11:   return 25;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string req, input logic got_v, input logic exp_v,
                       input int got_c, input int exp_c);
    n_checks++;
    if (got_v !== exp_v || got_c != exp_c) begin
      n_fail++;
      $display("FAIL %s: vend=%0b change=%0d expected vend=%0b change=%0d",
               req, got_v, got_c, exp_v, exp_c);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    coin  = 2'b00;
    @(negedge clk);
    rst_n = 1'b1;
    model_credit = 0;
  endtask

  // Drive one coin after a falling edge and compare the Mealy outputs before the next rising edge.
  task automatic step(input logic [1:0] c, input logic after_vend);
    int    total;
    logic  ev;
    int    ec;
    string tag;
    @(negedge clk);
    coin  = c;
    total = model_credit + cents_of(c);
    ev    = (total >= 20);
    ec    = ev ? (total - 20) / 5 : 0;
    if (c == 2'b11 && model_credit == 15) tag = "R7";
    else if (after_vend)                  tag = "R5";
    else if (ev)                          tag = "R3/R4";
    else if (c == 2'b00)                  tag = "R2";
    else                                  tag = "R6";
    model_credit = ev ? 0 : total;
    #5;
    check(tag, vend, ev, int'(change), ec);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    coin  = 2'b00;
    model_credit = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state shows no vend and no change
    #5;
    check("R1", vend, 1'b0, int'(change), 0);

    // R1: credit of 15 cents discarded by reset; a dime afterwards must not vend
    step(2'b01, 1'b0);
    step(2'b10, 1'b0);
    do_reset();
    step(2'b10, 1'b0);
    step(2'b01, 1'b0);
    do_reset();
    // R1: reset while credit is 5 cents, then quarter gives change code 1
    step(2'b01, 1'b0);
    do_reset();
    step(2'b11, 1'b0);

    // R2..R7: every sequence of length 1 to 4 from reset
    for (int len = 1; len <= 4; len++) begin
      for (int idx = 0; idx < (1 << (2 * len)); idx++) begin
        logic prev_vend;
        do_reset();
        prev_vend = 1'b0;
        for (int k = 0; k < len; k++) begin
          logic [1:0] c;
          int t;
          c = 2'((idx >> (2 * k)) & 3);
          t = model_credit + cents_of(c);
          step(c, prev_vend);
          prev_vend = (t >= 20);
        end
      end
    end

    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule